// File: doc/BRIEF.md
# Scaled-Index Adder Execution Unit

This unit sits in the integer pipeline of a 64-bit core, after operand fetch. Each cycle it may accept one 32-bit instruction word together with two 64-bit source values that were already read from the register file. It decodes the word and forms a scaled-index sum: the second source is shifted left by one to four places and added to the first. The result is registered and presented one clock later, together with the destination register number and a valid strobe.

There are two operations. The full-width form scales all 64 bits of the second source. The word form first clears the high 32 bits of the second source and then scales the low word, which suits unsigned 32-bit indices. Both forms wrap modulo 2^64. Any word whose opcode fields match neither form raises an illegal flag in place of a result.

The unit also passes the record bit through with a negative flag and a zero flag for the result. A condition-register stage outside the block can use them. The unit writes no condition bits.

Top module: `sa_unit`

## Requirements
- R1: Fields use MSB-0 numbering of the 32-bit word, where bit 0 is the most significant. Primary opcode is bits 0-5 (in_instr[31:26]). Destination is bits 6-10 (in_instr[25:21]), first source index 11-15, second source index 16-20. The shift field is bits 21-22 (in_instr[10:9]), the extended opcode bits 23-30 (in_instr[8:1]) and the record bit bit 31 (in_instr[0]). out_rt carries the destination field of the accepted word.
- R2: The shift distance is the 2-bit shift field plus one. Field values 0, 1, 2 and 3 shift by 1, 2, 3 and 4.
- R3: For the full-width form (primary opcode 22, extended opcode 110), out_result = ((in_rb << shift) + in_ra) mod 2^64. Bits shifted past bit 63 and the final carry are dropped.
- R4: For the word form (primary opcode 22, extended opcode 111), in_rb[63:32] has no effect. The result is (({32'b0, in_rb[31:0]} << shift) + in_ra) mod 2^64.
- R5: A legal word presented with in_valid high produces out_valid high, with its result, destination and flags, in the cycle after the accepting clock edge.
- R6: When in_valid is high and the word is neither form, the next cycle shows out_illegal high and out_valid low, and out_result, out_rt and the flags keep their earlier values. out_valid and out_illegal are never high together.
- R7: out_rc equals the record bit of the accepted word. out_neg equals bit 63 of the result, and out_zero is high exactly when the result is zero.
- R8: An asynchronous active-low reset (rst_n) clears out_valid, out_illegal, out_result, out_rt, out_rc, out_neg and out_zero.
- R9: A cycle with in_valid low gives out_valid and out_illegal low in the next cycle, and the result, destination and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present |
| in_instr | input | 32 | Instruction word |
| in_ra | input | 64 | Addend source value |
| in_rb | input | 64 | Scaled source value |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Accepted word was not a recognised form |
| out_rt | output | 5 | Destination register number |
| out_result | output | 64 | Scaled sum |
| out_rc | output | 1 | Record bit of the instruction |
| out_neg | output | 1 | Result bit 63 |
| out_zero | output | 1 | Result equals zero |

## Verification
The bench uses each shift field value with an all-ones scaled operand. A design that mapped the field without the bias of one, or that clipped the shift, would give wrong low or high bits there. It also uses operands whose top bits are set, so the sum must wrap. A design that kept a carry or widened the result would fail on those and would miss the zero flag when a wrap lands exactly on zero. Word-form tests place nonzero data in the high half of the scaled operand, so a missing mask shows up directly in the result. Illegal and idle cycles follow valid results, to catch a unit that still raises valid or overwrites the held result.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int ILEN = 32;
  localparam int RW   = 5;   // register index width
  localparam int SMW  = 2;   // shift field width

  typedef enum logic [1:0] {
    OP_FULL = 2'd0,
    OP_WORD = 2'd1,
    OP_BAD  = 2'd2
  } sa_op_e;

  typedef struct packed {
    sa_op_e          op;
    logic [RW-1:0]   rt;
    logic [SMW-1:0]  sm;
    logic            rc;
  } sa_dec_t;
endpackage

// File: rtl/sa_decode.sv
module sa_decode
  import sa_pkg::*;
#(
  parameter logic [5:0] PO_VAL  = 6'd22,
  parameter logic [7:0] XO_FULL = 8'd110,
  parameter logic [7:0] XO_WORD = 8'd111
) (
  input  logic [ILEN-1:0] instr,
  output sa_dec_t         dec
);
  // MSB-0 bit n of the word sits at instr[ILEN-1-n]
  localparam int PO_HI = ILEN - 1;
  localparam int RT_HI = ILEN - 7;
  localparam int SM_HI = ILEN - 22;
  localparam int XO_HI = ILEN - 24;

  logic [5:0] po_f;
  logic [7:0] xo_f;

  always_comb begin
    po_f   = instr[PO_HI -: 6];
    xo_f   = instr[XO_HI -: 8];
    dec.rt = instr[RT_HI -: RW];
    dec.sm = instr[SM_HI -: SMW];
    dec.rc = instr[0];
    if (po_f != PO_VAL)        dec.op = OP_BAD;
    else if (xo_f == XO_FULL)  dec.op = OP_FULL;
    else if (xo_f == XO_WORD)  dec.op = OP_WORD;
    else                       dec.op = OP_BAD;
  end
endmodule

// File: rtl/sa_scale_add.sv
module sa_scale_add
  import sa_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] ra,
  input  logic [XLEN-1:0] rb,
  input  logic [SMW-1:0]  sm,
  input  logic            word_mode,
  output logic [XLEN-1:0] sum
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] src;
  logic [XLEN-1:0] scaled;
  logic [SMW:0]    shamt;

  // low half always passes; high half is gated by the word mode
  genvar g;
  generate
    for (g = 0; g < XLEN; g++) begin : g_mask
      if (g < HALF) begin : g_lo
        assign src[g] = rb[g];
      end else begin : g_hi
        assign src[g] = rb[g] & ~word_mode;
      end
    end
  endgenerate

  always_comb begin
    shamt  = {1'b0, sm} + 1'b1;
    scaled = src << shamt;
    sum    = scaled + ra;
  end
endmodule

// File: rtl/sa_flags.sv
module sa_flags #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] value,
  output logic            neg,
  output logic            zero
);
  always_comb begin
    neg  = value[XLEN-1];
    zero = ~|value;
  end
endmodule

// File: rtl/sa_unit.sv
module sa_unit
  import sa_pkg::*;
#(
  parameter int         XLEN    = 64,
  parameter logic [5:0] PO_VAL  = 6'd22,
  parameter logic [7:0] XO_FULL = 8'd110,
  parameter logic [7:0] XO_WORD = 8'd111
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_ra,
  input  logic [XLEN-1:0] in_rb,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [4:0]      out_rt,
  output logic [XLEN-1:0] out_result,
  output logic            out_rc,
  output logic            out_neg,
  output logic            out_zero
);
  sa_dec_t         dec;
  logic [XLEN-1:0] sum;
  logic            neg_c, zero_c;
  logic            legal, load_en;
  logic            valid_d, illegal_d;

  sa_decode #(.PO_VAL(PO_VAL), .XO_FULL(XO_FULL), .XO_WORD(XO_WORD)) u_dec (
    .instr (in_instr),
    .dec   (dec)
  );

  sa_scale_add #(.XLEN(XLEN)) u_sa (
    .ra        (in_ra),
    .rb        (in_rb),
    .sm        (dec.sm),
    .word_mode (dec.op == OP_WORD),
    .sum       (sum)
  );

  sa_flags #(.XLEN(XLEN)) u_flg (
    .value (sum),
    .neg   (neg_c),
    .zero  (zero_c)
  );

  // next-state
  always_comb begin
    legal     = (dec.op != OP_BAD);
    valid_d   = in_valid & legal;
    illegal_d = in_valid & ~legal;
    load_en   = valid_d;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= valid_d;
      out_illegal <= illegal_d;
    end
  end

  // data registers with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_result <= '0;
      out_rt     <= '0;
      out_rc     <= 1'b0;
      out_neg    <= 1'b0;
      out_zero   <= 1'b0;
    end else if (load_en) begin
      out_result <= sum;
      out_rt     <= dec.rt;
      out_rc     <= dec.rc;
      out_neg    <= neg_c;
      out_zero   <= zero_c;
    end
  end

  assert_valid_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal) |=> out_valid);
  assert_illegal_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal) |=> (out_illegal && !out_valid));
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_illegal));
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));
  assert_neg_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_neg == out_result[XLEN-1]));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_illegal && $stable(out_result) && $stable(out_rt)));
endmodule

// File: tb/tb_sa_unit.sv
module tb_sa_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_instr;
  logic [63:0] in_ra, in_rb;
  logic        out_valid, out_illegal, out_rc, out_neg, out_zero;
  logic [4:0]  out_rt;
  logic [63:0] out_result;

  int total = 0;
  int bad   = 0;
  logic [63:0] held;
  logic [4:0]  held_rt;

  always #2.5 clk = ~clk;

  sa_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .in_ra(in_ra), .in_rb(in_rb), .out_valid(out_valid), .out_illegal(out_illegal),
    .out_rt(out_rt), .out_result(out_result), .out_rc(out_rc),
    .out_neg(out_neg), .out_zero(out_zero)
  );

  function automatic logic [31:0] enc(input logic [5:0] po, input logic [4:0] rt,
      input logic [1:0] sm, input logic [7:0] xo, input logic rc);
    return {po, rt, 5'd1, 5'd2, sm, xo, rc};
  endfunction

  function automatic logic [63:0] ref_sum(input logic [63:0] a, input logic [63:0] b,
      input logic [1:0] sm, input logic word);
    logic [63:0] n;
    n = word ? {32'd0, b[31:0]} : b;
    return (n << (int'(sm) + 1)) + a;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive on a falling edge, check at the following falling edge
  task automatic run_op(input string req, input logic [31:0] ins,
      input logic [63:0] a, input logic [63:0] b, input logic word, input logic legal);
    logic [63:0] e;
    in_valid = 1'b1; in_instr = ins; in_ra = a; in_rb = b;
    e = ref_sum(a, b, ins[10:9], word);
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (legal) begin
      chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
      chk({req, " result"}, out_result, e);
      chk({req, " rt"}, {59'd0, out_rt}, {59'd0, ins[25:21]});
      chk({req, " R7 rc"}, {63'd0, out_rc}, {63'd0, ins[0]});
      chk({req, " R7 neg"}, {63'd0, out_neg}, {63'd0, e[63]});
      chk({req, " R7 zero"}, {63'd0, out_zero}, {63'd0, (e == 64'd0)});
      held = e; held_rt = ins[25:21];
    end else begin
      chk({req, " illegal"}, {62'd0, out_illegal, out_valid}, 64'd2);
      chk({req, " hold"}, out_result, held);
      chk({req, " hold rt"}, {59'd0, out_rt}, {59'd0, held_rt});
    end
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0; in_valid = 1'b0; in_instr = '0; in_ra = '0; in_rb = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 valid", {62'd0, out_valid, out_illegal}, 64'd0);
    chk("R8 result", out_result, 64'd0);
    chk("R8 flags", {61'd0, out_rc, out_neg, out_zero}, 64'd0);
    rst_n = 1'b1;
    held = '0; held_rt = '0;
    @(negedge clk);

    // R2/R3 every shift field with all-ones scaled operand
    for (int s = 0; s < 4; s++)
      run_op("R2 R3 sm", enc(6'd22, 5'(s + 3), 2'(s), 8'd110, 1'b1),
             64'h0123_4567_89ab_cdef, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
    // R3 wrap to exactly zero
    run_op("R3 wrap zero", enc(6'd22, 5'd9, 2'd0, 8'd110, 1'b0),
           64'd0, 64'h8000_0000_0000_0000, 1'b0, 1'b1);
    // R3 carry out dropped
    run_op("R3 carry", enc(6'd22, 5'd10, 2'd3, 8'd110, 1'b1),
           64'hF000_0000_0000_0001, 64'h1000_0000_0000_0000, 1'b0, 1'b1);
    // R4 word form with junk in high half, every shift
    for (int s = 0; s < 4; s++)
      run_op("R4 word sm", enc(6'd22, 5'(s + 20), 2'(s), 8'd111, 1'b0),
             64'hFFFF_FFFF_0000_0005, 64'hDEAD_BEEF_8000_0001, 1'b1, 1'b1);
    // R1 field placement: destination 31, record bit set
    run_op("R1 fields", enc(6'd22, 5'd31, 2'd1, 8'd110, 1'b1),
           64'd7, 64'd3, 1'b0, 1'b1);
    // R6 wrong primary, wrong extended
    run_op("R6 bad po", enc(6'd23, 5'd4, 2'd1, 8'd110, 1'b0),
           64'd1, 64'd1, 1'b0, 1'b0);
    run_op("R6 bad xo", enc(6'd22, 5'd4, 2'd1, 8'd112, 1'b0),
           64'd1, 64'd1, 1'b0, 1'b0);
    // R9 idle cycle holds
    in_valid = 1'b0; in_ra = 64'hAAAA; in_rb = 64'h5555;
    in_instr = enc(6'd22, 5'd2, 2'd0, 8'd110, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R9 idle flags", {62'd0, out_valid, out_illegal}, 64'd0);
    chk("R9 idle result", out_result, held);
    chk("R9 idle rt", {59'd0, out_rt}, {59'd0, held_rt});

    // R5 back-to-back random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins;
      logic [7:0]  xo;
      logic [5:0]  po;
      logic        lg, wd;
      int          pick;
      pick = $urandom_range(0, 9);
      po = (pick == 9) ? 6'($urandom_range(0, 63)) : 6'd22;
      xo = (pick < 4) ? 8'd110 : (pick < 8) ? 8'd111 : 8'($urandom_range(0, 255));
      lg = (po == 6'd22) && (xo == 8'd110 || xo == 8'd111);
      wd = (xo == 8'd111);
      ins = {po, 5'($urandom_range(0, 31)), 10'($urandom), 2'($urandom_range(0, 3)),
             xo, 1'($urandom_range(0, 1))};
      run_op("R5 rand", ins, {$urandom, $urandom}, {$urandom, $urandom}, wd, lg);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule